// File: doc/BRIEF.md
# Automatic Request-to-Send Flow Control

This block produces the active-low request-to-send line of one serial channel. Software owns a single stored output bit, and the line is driven low while that bit is 1. Two automatic features can override the line without further software action. Each one has its own enable.

The first is receive-side throttling. A detected start bit that arrives while the receive FIFO is full forces the line high. This tells the far transmitter to pause. The stored bit is left untouched, so the line returns low as soon as the FIFO is no longer full.

The second is transmit-side line turnaround for half-duplex links. Software enables the feature and enables the transmitter, then sets the stored bit and queues the message. It disables the transmitter once the last character is queued. When the shifter and the transmit FIFO have fully drained with the transmitter disabled, the block waits one further bit time. It then clears the stored bit, which releases the line.

Top module: `rts_flow_ctrl`

## Requirements
- R1: Out of reset the stored bit is 0 and `rtsn` is 1. A `port_wr` pulse loads `port_wr_val` into the stored bit at the next clock edge. `rtsn` is 0 when the stored bit is 1 and no receive blanking is active, and 1 otherwise.
- R2: The receive blanking flag sets at the clock edge where `rx_auto_en`, `rx_start` and `rx_fifo_full` are all 1. While the flag is set, `rtsn` is 1.
- R3: Receive blanking never changes the stored bit. The blanking flag clears at the first clock edge where `rx_fifo_full` is 0, and `rtsn` then returns to 0 if the stored bit is still 1.
- R4: A start bit has no effect on `rtsn` while `rx_auto_en` is 0 or while `rx_fifo_full` is 0. Clearing `rx_auto_en` also releases any active blanking at the next edge.
- R5: The turnaround counter arms when `tx_auto_en` is 1, `tx_enable` is 0 and `tx_idle` is 1. Counting begins at the clock edge after that condition first holds. At the edge that samples the TICKS_PER_BIT-th `bit_tick` during counting, the stored bit is cleared.
- R6: Any cycle in which the arming condition fails aborts the count, for example when new data makes `tx_idle` 0 or when `tx_enable` is 1. A later count restarts from zero.
- R7: While `tx_auto_en` is 0, the stored bit is never cleared automatically.
- R8: A `port_wr` in the same cycle as an automatic clear wins. The automatic clear fires at most once per drain, so re-setting the bit while the arming condition stays true is not undone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_wr | input | 1 | Write strobe for the stored output bit |
| port_wr_val | input | 1 | Value written to the stored output bit |
| rx_auto_en | input | 1 | Enables receive-side throttling |
| tx_auto_en | input | 1 | Enables transmit-side turnaround |
| rx_start | input | 1 | One-cycle pulse for each valid received start bit |
| rx_fifo_full | input | 1 | Receive FIFO has no free slot |
| tx_idle | input | 1 | Transmit shifter and FIFO empty, stop bits sent |
| tx_enable | input | 1 | Transmitter enable |
| bit_tick | input | 1 | Sub-bit timing tick; TICKS_PER_BIT ticks make one bit time |
| rtsn | output | 1 | Active-low request-to-send |

## Verification
Every result is due exactly one clock edge after the input that causes it:
- a port write, a blanking set, a blanking release or an aborted count appears at `rtsn` after the next edge;
- the turnaround clear follows the edge that samples the last needed tick, and the arming edge itself counts no tick.

The bench changes inputs on the falling edge, steps through one rising edge, and samples `rtsn` on the following falling edge, so each check lands in the cycle the requirement names. The turnaround delay is swept over every tick count from zero to one full bit time. Each abort case and the same-cycle write-versus-clear case is checked at the exact boundary tick.

// File: rtl/rts_pkg.sv
package rts_pkg;

    typedef enum logic [1:0] {
        TA_WAIT  = 2'd0,
        TA_COUNT = 2'd1,
        TA_DONE  = 2'd2
    } ta_state_e;

    typedef struct packed {
        logic auto_en;
        logic enabled;
        logic idle;
    } tx_view_t;

    function automatic logic ta_armed(input tx_view_t v);
        return v.auto_en && !v.enabled && v.idle;
    endfunction

    function automatic logic rts_level_n(input logic stored, input logic blank);
        return !(stored && !blank);
    endfunction

endpackage

// File: rtl/rts_port_bit.sv
module rts_port_bit (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wr_val,
    input  logic auto_clr,
    output logic bit_q
);
    always_ff @(posedge clk) begin
        if (rst)
            bit_q <= 1'b0;
        else if (wr)
            bit_q <= wr_val;
        else if (auto_clr)
            bit_q <= 1'b0;
    end
endmodule

// File: rtl/rts_rx_gate.sv
module rts_rx_gate (
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic start_seen,
    input  logic fifo_full,
    output logic blank_q
);
    logic set_c;
    logic rel_c;

    assign set_c = auto_en && start_seen && fifo_full;
    assign rel_c = !fifo_full || !auto_en;

    always_ff @(posedge clk) begin
        if (rst)
            blank_q <= 1'b0;
        else if (set_c)
            blank_q <= 1'b1;
        else if (rel_c)
            blank_q <= 1'b0;
    end
endmodule

// File: rtl/rts_tx_turn.sv
module rts_tx_turn
    import rts_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  tx_view_t tx,
    input  logic     tick,
    output logic     clr_pulse
);
    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

    ta_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             armed;

    assign armed     = ta_armed(tx);
    assign clr_pulse = (state_q == TA_COUNT) && armed && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TA_WAIT;
            cnt_q   <= '0;
        end else if (!armed) begin
            state_q <= TA_WAIT;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                TA_WAIT: begin
                    state_q <= TA_COUNT;
                    cnt_q   <= '0;
                end
                TA_COUNT: begin
                    if (tick) begin
                        if (cnt_q == LAST)
                            state_q <= TA_DONE;
                        else
                            cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= TA_DONE;
            endcase
        end
    end
endmodule

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl
    import rts_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic port_wr,
    input  logic port_wr_val,
    input  logic rx_auto_en,
    input  logic tx_auto_en,
    input  logic rx_start,
    input  logic rx_fifo_full,
    input  logic tx_idle,
    input  logic tx_enable,
    input  logic bit_tick,
    output logic rtsn
);
    logic     port_q;
    logic     blank_q;
    logic     clr_pulse;
    tx_view_t tx_v;

    assign tx_v = '{auto_en: tx_auto_en, enabled: tx_enable, idle: tx_idle};

    rts_port_bit u_port (
        .clk(clk), .rst(rst), .wr(port_wr), .wr_val(port_wr_val),
        .auto_clr(clr_pulse), .bit_q(port_q)
    );

    rts_rx_gate u_rx (
        .clk(clk), .rst(rst), .auto_en(rx_auto_en), .start_seen(rx_start),
        .fifo_full(rx_fifo_full), .blank_q(blank_q)
    );

    rts_tx_turn #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_tx (
        .clk(clk), .rst(rst), .tx(tx_v), .tick(bit_tick), .clr_pulse(clr_pulse)
    );

    assign rtsn = rts_level_n(port_q, blank_q);
endmodule

// File: rtl/rts_flow_ctrl_chk.sv
module rts_flow_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic port_wr,
    input logic port_wr_val,
    input logic rx_auto_en,
    input logic rx_start,
    input logic rx_fifo_full,
    input logic tx_auto_en,
    input logic tx_enable,
    input logic tx_idle,
    input logic bit_tick,
    input logic port_q,
    input logic blank_q,
    input logic clr_pulse,
    input logic rtsn
);
    p_write_r1: assert property (@(posedge clk) disable iff (rst)
        port_wr |=> (port_q == $past(port_wr_val)));

    p_blank_set_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_auto_en && rx_start && rx_fifo_full) |=> rtsn);

    p_keep_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (!port_wr && !clr_pulse) |=> $stable(port_q));

    p_release_r3: assert property (@(posedge clk) disable iff (rst)
        !rx_fifo_full |=> !blank_q);

    p_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (!rx_auto_en && !blank_q) |=> !blank_q);

    p_clr_cond_r5: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |-> (tx_auto_en && !tx_enable && tx_idle && bit_tick));

    p_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_enable || !tx_idle) |=> !clr_pulse);

    p_off_r7: assert property (@(posedge clk) disable iff (rst)
        !tx_auto_en |-> !clr_pulse);

    p_prio_r8: assert property (@(posedge clk) disable iff (rst)
        (port_wr && clr_pulse) |=> (port_q == $past(port_wr_val)));
endmodule

bind rts_flow_ctrl rts_flow_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .port_wr(port_wr), .port_wr_val(port_wr_val),
    .rx_auto_en(rx_auto_en), .rx_start(rx_start), .rx_fifo_full(rx_fifo_full),
    .tx_auto_en(tx_auto_en), .tx_enable(tx_enable), .tx_idle(tx_idle),
    .bit_tick(bit_tick), .port_q(port_q), .blank_q(blank_q),
    .clr_pulse(clr_pulse), .rtsn(rtsn)
);

// File: tb/rts_flow_ctrl_tb.sv
module rts_flow_ctrl_tb;
    localparam int T = 4;

    logic clk = 1'b0;
    logic rst, port_wr, port_wr_val, rx_auto_en, tx_auto_en, rx_start;
    logic rx_fifo_full, tx_idle, tx_enable, bit_tick;
    logic rtsn;
    int checks = 0;
    int errs = 0;

    always #4 clk = ~clk;

    rts_flow_ctrl #(.TICKS_PER_BIT(T)) u_dut (
        .clk(clk), .rst(rst), .port_wr(port_wr), .port_wr_val(port_wr_val),
        .rx_auto_en(rx_auto_en), .tx_auto_en(tx_auto_en), .rx_start(rx_start),
        .rx_fifo_full(rx_fifo_full), .tx_idle(tx_idle), .tx_enable(tx_enable),
        .bit_tick(bit_tick), .rtsn(rtsn)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: rtsn=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic v);
        port_wr = 1'b1; port_wr_val = v;
        step();
        port_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
        end
    endtask

    // Drain start: idle low while setting the bit, then idle high for the arming edge.
    task automatic arm_fresh();
        tx_idle = 1'b0;
        wr(1'b1);
        tx_idle = 1'b1;
        step();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        finish_run();
    end

    initial begin
        rst = 1'b1; port_wr = 0; port_wr_val = 0; rx_auto_en = 0; tx_auto_en = 0;
        rx_start = 0; rx_fifo_full = 0; tx_idle = 0; tx_enable = 1; bit_tick = 0;
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        step();
        chk("R1 reset", rtsn, 1'b1);

        // R1: the line follows the stored bit
        wr(1'b1); chk("R1 write 1", rtsn, 1'b0);
        wr(1'b0); chk("R1 write 0", rtsn, 1'b1);
        wr(1'b1); chk("R1 write 1 again", rtsn, 1'b0);

        // R4: start bits with throttling off, or with the FIFO not full
        rx_fifo_full = 1; rx_start = 1; step(); rx_start = 0;
        chk("R4 disabled start", rtsn, 1'b0);
        rx_auto_en = 1; rx_fifo_full = 0; rx_start = 1; step(); rx_start = 0;
        chk("R4 not full start", rtsn, 1'b0);

        // R2: full FIFO and a start bit blank the line; R3: release when space appears
        rx_fifo_full = 1; step();
        chk("R2 full without start", rtsn, 1'b0);
        rx_start = 1; step(); rx_start = 0;
        chk("R2 blank set", rtsn, 1'b1);
        step(); step();
        chk("R2 blank held", rtsn, 1'b1);
        rx_fifo_full = 0; step();
        chk("R3 release keeps bit", rtsn, 1'b0);

        // R4: disabling throttling releases an active blank
        rx_fifo_full = 1; rx_start = 1; step(); rx_start = 0;
        chk("R2 blank set again", rtsn, 1'b1);
        rx_auto_en = 0; step();
        chk("R4 disable releases", rtsn, 1'b0);
        rx_fifo_full = 0;

        // R5: sweep the number of ticks after the drain
        tx_auto_en = 1; tx_enable = 0;
        for (int k = 0; k <= T + 1; k++) begin
            arm_fresh();
            ticks(k);
            chk($sformatf("R5 after %0d ticks", k), rtsn, (k >= T) ? 1'b1 : 1'b0);
        end

        // R5: cycles without a tick do not count
        arm_fresh();
        ticks(T - 1);
        repeat (3 * T) step();
        chk("R5 idle cycles not counted", rtsn, 1'b0);
        ticks(1);
        chk("R5 last tick clears", rtsn, 1'b1);

        // R6: new data aborts the count
        arm_fresh();
        ticks(T - 1);
        tx_idle = 0; step(); tx_idle = 1; step();
        ticks(T - 1);
        chk("R6 abort by load", rtsn, 1'b0);
        ticks(1);
        chk("R6 restart completes", rtsn, 1'b1);

        // R6: re-enabling the transmitter aborts and blocks the count
        arm_fresh();
        ticks(T - 1);
        tx_enable = 1; step();
        ticks(2 * T);
        chk("R6 enabled never clears", rtsn, 1'b0);
        tx_enable = 0; step();
        ticks(T - 1);
        chk("R6 abort by enable", rtsn, 1'b0);
        ticks(1);
        chk("R6 after enable drop", rtsn, 1'b1);

        // R7: turnaround feature off
        tx_auto_en = 0;
        arm_fresh();
        ticks(3 * T);
        chk("R7 feature off", rtsn, 1'b0);
        tx_auto_en = 1;

        // R8: a write in the clearing cycle wins, and no second clear follows
        arm_fresh();
        ticks(T - 1);
        bit_tick = 1; port_wr = 1; port_wr_val = 1;
        step();
        bit_tick = 0; port_wr = 0;
        chk("R8 write beats clear", rtsn, 1'b0);
        ticks(3 * T);
        chk("R8 single clear per drain", rtsn, 1'b0);

        // R8: re-set after a completed clear is not undone
        arm_fresh();
        ticks(T);
        chk("R8 cleared", rtsn, 1'b1);
        wr(1'b1);
        ticks(3 * T);
        chk("R8 re-set survives", rtsn, 1'b0);

        finish_run();
    end
endmodule